// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the 32-bit architectural registers of a processor core that switches between seven operating modes. A 5-bit mode input picks which physical copy stands behind each of the register numbers R0 to R15. Low registers are common to all modes. A middle group has a private copy for the fast-interrupt mode. The stack-pointer and link registers have one copy per exception mode, and the user and system modes share one copy. R15 has no storage here. It reads as the current instruction address taken from an input, rounded down to a word boundary and advanced by two instructions.

The core gets two combinational read ports and one write port, each addressed by a 4-bit register number. It also gets a saved-status port that reaches the status save slot of the current mode. Only the five exception modes own such a slot. In user or system mode, an access through this port flags an error for that cycle and reads as zero, and a write has no effect. All writes take effect at the clock edge, so a read in the same cycle still returns the previous contents.

Top module: `banked_regfile`

## Requirements
- R1: After a synchronous reset, every stored register and every saved-status slot reads as zero.
- R2: Registers 0 to 7 have one physical copy each, and a write made in any mode is seen in every other mode.
- R3: Registers 8 to 12 have two copies each. Fast-interrupt mode (10001) uses one copy and every other mode uses the other.
- R4: Registers 13 and 14 have six copies each. User (10000) and system (11111) share one copy, and fast-interrupt, interrupt, supervisor, abort and undefined modes each have a private one.
- R5: The mode codes are: user 10000, fast-interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011, system 11111.
- R6: Reading register 15 on either port returns the instruction address input with bits [1:0] cleared, plus 8, modulo 2^32. Bits [1:0] of the result are always zero.
- R7: A write to register 15 changes no stored register.
- R8: Each of the five exception modes has its own saved-status slot. A write through the saved-status port in one of these modes is read back in that mode, and no other mode sees it.
- R9: In user or system mode, the saved-status read data is zero and a saved-status write is ignored. The error output is high in exactly the cycles where the read or write request is asserted in such a mode.
- R10: A mode code not listed in R5 maps registers exactly as user mode does and owns no saved-status slot.
- R11: A read of a register that is being written in the same cycle returns the old value. The new value is visible from the next cycle on.
- R12: The two read ports are independent. Each returns the register named by its own index in the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 5 | Current operating mode code |
| pc_i | input | 32 | Address of the instruction being executed |
| rd_a_idx | input | 4 | Register number, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Register number, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Register write request |
| wr_idx | input | 4 | Register number to write |
| wr_data | input | 32 | Register write data |
| sps_rd_en | input | 1 | Saved-status read request |
| sps_rd_data | output | 32 | Saved-status slot of the current mode |
| sps_wr_en | input | 1 | Saved-status write request |
| sps_wr_data | input | 32 | Saved-status write data |
| sps_err | output | 1 | Saved-status access in a mode without a slot |

## Verification
Each register group is written in one mode and read back in every mode, including system, which must alias user for registers 13 and 14. This separates shared copies from banked ones and shows whether a mode lands in the wrong bank. Distinct values per mode and per register number expose swapped indices and crossed copies. Instruction addresses with low bits set and at the top of the address space exercise the R15 view. Reads made in the same cycle as a write to the same register, writes to R15, saved-status accesses in user and system mode, and unlisted mode codes cover the remaining corners.

// File: rtl/brf_pkg.sv
package brf_pkg;

    // Operating mode codes
    localparam logic [4:0] MODE_USR = 5'b10000;
    localparam logic [4:0] MODE_FIQ = 5'b10001;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_UND = 5'b11011;
    localparam logic [4:0] MODE_SYS = 5'b11111;

    // Register grouping
    localparam int HI_FIRST  = 8;    // first register with a fast-interrupt copy
    localparam int SP_IDX    = 13;   // first per-mode register
    localparam int LR_IDX    = 14;   // last per-mode register
    localparam int PC_IDX    = 15;   // program counter view, not stored
    localparam int NUM_BANKS = 6;
    localparam int NUM_HI    = SP_IDX - HI_FIRST;
    localparam int FIQ_BASE  = SP_IDX;
    localparam int PAIR_BASE = FIQ_BASE + NUM_HI;
    localparam int PAIR_SIZE = LR_IDX - SP_IDX + 1;
    localparam int NUM_PHYS  = PAIR_BASE + PAIR_SIZE * NUM_BANKS;
    localparam int PHYS_AW   = $clog2(NUM_PHYS);
    localparam int PC_AHEAD  = 8;

    typedef enum logic [2:0] {
        BANK_USR = 3'd0,
        BANK_FIQ = 3'd1,
        BANK_IRQ = 3'd2,
        BANK_SVC = 3'd3,
        BANK_ABT = 3'd4,
        BANK_UND = 3'd5
    } bank_e;

    typedef struct packed {
        bank_e bank;
        logic  has_saved;
    } mode_info_t;

    function automatic mode_info_t decode_mode(logic [4:0] m);
        mode_info_t r;
        r.has_saved = 1'b1;
        case (m)
            MODE_FIQ: r.bank = BANK_FIQ;
            MODE_IRQ: r.bank = BANK_IRQ;
            MODE_SVC: r.bank = BANK_SVC;
            MODE_ABT: r.bank = BANK_ABT;
            MODE_UND: r.bank = BANK_UND;
            default: begin
                r.bank      = BANK_USR;
                r.has_saved = 1'b0;
            end
        endcase
        return r;
    endfunction

    function automatic logic [PHYS_AW-1:0] phys_index(bank_e b, logic [3:0] idx);
        int n;
        int i;
        i = int'(idx);
        if (i < HI_FIRST)
            n = i;
        else if (i < SP_IDX)
            n = (b == BANK_FIQ) ? FIQ_BASE + (i - HI_FIRST) : i;
        else if (i <= LR_IDX)
            n = PAIR_BASE + PAIR_SIZE * int'(b) + (i - SP_IDX);
        else
            n = 0;
        return PHYS_AW'(n);
    endfunction

endpackage

// File: rtl/brf_mode_decode.sv
module brf_mode_decode
    import brf_pkg::*;
(
    input  logic [4:0] mode_i,
    output mode_info_t info_o
);
    always_comb info_o = decode_mode(mode_i);
endmodule

// File: rtl/brf_gpr_store.sv
module brf_gpr_store
    import brf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_RD = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  bank_e             bank_i,
    input  logic [DATA_W-1:0] pc_view_i,
    input  logic [3:0]        rd_idx_i  [NUM_RD],
    output logic [DATA_W-1:0] rd_data_o [NUM_RD],
    input  logic              wr_en_i,
    input  logic [3:0]        wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i
);
    logic [DATA_W-1:0] regs_q [NUM_PHYS];
    logic              wr_hit;
    logic [PHYS_AW-1:0] wr_slot;

    assign wr_hit  = wr_en_i && (int'(wr_idx_i) != PC_IDX);
    assign wr_slot = phys_index(bank_i, wr_idx_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_PHYS; k++) regs_q[k] <= '0;
        end else if (wr_hit) begin
            regs_q[wr_slot] <= wr_data_i;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        logic [PHYS_AW-1:0] slot;
        assign slot = phys_index(bank_i, rd_idx_i[p]);
        assign rd_data_o[p] = (int'(rd_idx_i[p]) == PC_IDX) ? pc_view_i : regs_q[slot];
    end
endmodule

// File: rtl/brf_saved_status.sv
module brf_saved_status
    import brf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_info_t        info_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] slot_view [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_slot
        if (g == int'(BANK_USR)) begin : g_none
            assign slot_view[g] = '0;
        end else begin : g_keep
            logic [DATA_W-1:0] val_q;
            always_ff @(posedge clk) begin
                if (rst)
                    val_q <= '0;
                else if (wr_en_i && info_i.has_saved && (int'(info_i.bank) == g))
                    val_q <= wr_data_i;
            end
            assign slot_view[g] = val_q;
        end
    end

    assign rd_data_o = info_i.has_saved ? slot_view[info_i.bank] : '0;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import brf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        mode_i,
    input  logic [DATA_W-1:0] pc_i,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sps_rd_en,
    output logic [DATA_W-1:0] sps_rd_data,
    input  logic              sps_wr_en,
    input  logic [DATA_W-1:0] sps_wr_data,
    output logic              sps_err
);
    localparam int NUM_RD = 2;
    localparam logic [DATA_W-1:0] WORD_MASK = ~DATA_W'(3);

    mode_info_t        info;
    logic [DATA_W-1:0] pc_view;
    logic [3:0]        rd_idx  [NUM_RD];
    logic [DATA_W-1:0] rd_data [NUM_RD];

    brf_mode_decode u_decode (
        .mode_i (mode_i),
        .info_o (info)
    );

    assign pc_view   = (pc_i & WORD_MASK) + DATA_W'(PC_AHEAD);
    assign rd_idx[0] = rd_a_idx;
    assign rd_idx[1] = rd_b_idx;

    brf_gpr_store #(.DATA_W(DATA_W), .NUM_RD(NUM_RD)) u_gpr (
        .clk       (clk),
        .rst       (rst),
        .bank_i    (info.bank),
        .pc_view_i (pc_view),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

    brf_saved_status #(.DATA_W(DATA_W)) u_saved (
        .clk       (clk),
        .rst       (rst),
        .info_i    (info),
        .wr_en_i   (sps_wr_en),
        .wr_data_i (sps_wr_data),
        .rd_data_o (sps_rd_data)
    );

    assign sps_err = !info.has_saved && (sps_rd_en || sps_wr_en);
endmodule

// File: rtl/brf_checker.sv
module brf_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [4:0]        mode_i,
    input logic [DATA_W-1:0] pc_i,
    input logic [3:0]        rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [3:0]        rd_b_idx,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [3:0]        wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              sps_rd_en,
    input logic [DATA_W-1:0] sps_rd_data,
    input logic              sps_wr_en,
    input logic [DATA_W-1:0] sps_wr_data,
    input logic              sps_err
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && rd_a_idx != 4'd15) |-> (rd_a_data == '0));

    p_low_shared_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && wr_en && wr_idx < 4'd8) && rd_a_idx == $past(wr_idx))
        |-> (rd_a_data == $past(wr_data)));

    p_pc_aligned_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_b_idx == 4'd15) |-> (rd_b_data[1:0] == 2'b00));

    p_pc_step_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == 4'd15 && $past(rd_a_idx) == 4'd15 && pc_i == $past(pc_i) + DATA_W'(4))
        |-> (rd_a_data == $past(rd_a_data) + DATA_W'(4)));

    p_saved_write_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && sps_wr_en && !sps_err) && mode_i == $past(mode_i))
        |-> (sps_rd_data == $past(sps_wr_data)));

    p_no_slot_zero_r9: assert property (@(posedge clk) disable iff (rst)
        sps_err |-> (sps_rd_data == '0));

    p_err_needs_access_r9: assert property (@(posedge clk) disable iff (rst)
        sps_err |-> (sps_rd_en || sps_wr_en));

    p_write_lands_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && wr_en && wr_idx != 4'd15) && mode_i == $past(mode_i)
         && rd_a_idx == $past(wr_idx))
        |-> (rd_a_data == $past(wr_data)));

    p_ports_agree_r12: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));
endmodule

bind banked_regfile brf_checker #(.DATA_W(DATA_W)) u_brf_checker (.*);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;

    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;
    localparam logic [4:0] M_SYS = 5'b11111;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  mode_i = M_USR;
    logic [31:0] pc_i = '0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, sps_rd_data, sps_wr_data = '0;
    logic        wr_en = 1'b0, sps_rd_en = 1'b0, sps_wr_en = 1'b0, sps_err;

    always #4 clk = ~clk;   // 125 MHz

    banked_regfile i_banked_regfile (
        .clk(clk), .rst(rst), .mode_i(mode_i), .pc_i(pc_i),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sps_rd_en(sps_rd_en), .sps_rd_data(sps_rd_data),
        .sps_wr_en(sps_wr_en), .sps_wr_data(sps_wr_data), .sps_err(sps_err)
    );

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] s;
        logic        e;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          fails = 0;
    bit          finished = 0;
    logic [31:0] mdl [6][16];
    logic [31:0] smdl [6];
    logic [31:0] cur_pc = 32'h0000_1000;
    logic [4:0]  all_modes [7] = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS};

    // Reference view from the requirements: bank class 0 is user/system/unlisted
    function automatic int cls_of(logic [4:0] m);
        case (m)
            M_FIQ: return 1;
            M_IRQ: return 2;
            M_SVC: return 3;
            M_ABT: return 4;
            M_UND: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic bit shares(int c, int k, int i);
        if (i < 8) return 1'b1;
        if (i < 13) return (c == 1) == (k == 1);
        return c == k;
    endfunction

    function automatic logic [31:0] reg_view(int c, logic [3:0] i, logic [31:0] pc);
        if (i == 4'd15) return {pc[31:2], 2'b00} + 32'd8;
        return mdl[c][i];
    endfunction

    task automatic step(input logic [4:0] m, input logic [3:0] ia, input logic [3:0] ib,
                        input logic we, input logic [3:0] wi, input logic [31:0] wd,
                        input logic srd, input logic swe, input logic [31:0] swd,
                        input string tag);
        exp_t x;
        int   c;
        @(negedge clk);
        mode_i = m; pc_i = cur_pc; rd_a_idx = ia; rd_b_idx = ib;
        wr_en = we; wr_idx = wi; wr_data = wd;
        sps_rd_en = srd; sps_wr_en = swe; sps_wr_data = swd;
        c = cls_of(m);
        x.a = reg_view(c, ia, cur_pc);
        x.b = reg_view(c, ib, cur_pc);
        x.s = (c != 0) ? smdl[c] : 32'h0;
        x.e = (c == 0) && (srd || swe);
        x.tag = tag;
        sb.push_back(x);
        if (we && wi != 4'd15)
            for (int k = 0; k < 6; k++)
                if (shares(c, k, int'(wi))) mdl[k][wi] = wd;
        if (swe && c != 0) smdl[c] = swd;
    endtask

    task automatic rd(input logic [4:0] m, input logic [3:0] ia, input logic [3:0] ib, input string tag);
        step(m, ia, ib, 1'b0, 4'd0, 32'h0, 1'b0, 1'b0, 32'h0, tag);
    endtask

    task automatic wr(input logic [4:0] m, input logic [3:0] wi, input logic [31:0] wd, input string tag);
        step(m, wi, 4'd15, 1'b1, wi, wd, 1'b0, 1'b0, 32'h0, tag);
    endtask

    task automatic sr(input logic [4:0] m, input string tag);
        step(m, 4'd0, 4'd1, 1'b0, 4'd0, 32'h0, 1'b1, 1'b0, 32'h0, tag);
    endtask

    task automatic sw(input logic [4:0] m, input logic [31:0] d, input string tag);
        step(m, 4'd2, 4'd3, 1'b0, 4'd0, 32'h0, 1'b0, 1'b1, d, tag);
    endtask

    // Monitor: compares the oldest expected item shortly before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                checks++;
                if (rd_a_data !== x.a || rd_b_data !== x.b || sps_rd_data !== x.s || sps_err !== x.e) begin
                    fails++;
                    $display("FAIL %s: a=%h/%h b=%h/%h sps=%h/%h err=%b/%b (actual/expected)",
                             x.tag, rd_a_data, x.a, rd_b_data, x.b, sps_rd_data, x.s, sps_err, x.e);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete (actual hung, expected done)");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 6; k++) begin
            smdl[k] = '0;
            for (int i = 0; i < 16; i++) mdl[k][i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: all storage zero after reset
        foreach (all_modes[k])
            for (int i = 0; i < 15; i++) rd(all_modes[k], 4'(i), 4'(14 - i), "R1");
        foreach (all_modes[k]) sr(all_modes[k], "R1");

        // R2: low registers shared by every mode
        for (int i = 0; i < 8; i++) wr(M_SVC, 4'(i), 32'hA000_0000 + i, "R2");
        foreach (all_modes[k])
            for (int i = 0; i < 8; i++) rd(all_modes[k], 4'(i), 4'(7 - i), "R2");

        // R3: middle group, fast-interrupt copy apart
        for (int i = 8; i < 13; i++) begin
            wr(M_USR, 4'(i), 32'h0800_0000 + i, "R3");
            wr(M_FIQ, 4'(i), 32'h0F00_0000 + i, "R3");
        end
        foreach (all_modes[k])
            for (int i = 8; i < 13; i++) rd(all_modes[k], 4'(i), 4'(20 - i), "R3");

        // R4/R5: six copies of 13 and 14, user and system aliased
        foreach (all_modes[k]) begin
            wr(all_modes[k], 4'd13, 32'h1300_0000 + k, "R4/R5");
            wr(all_modes[k], 4'd14, 32'h1400_0000 + k, "R4/R5");
        end
        foreach (all_modes[k]) rd(all_modes[k], 4'd13, 4'd14, "R4/R5");

        // R6: program counter view
        cur_pc = 32'h0000_0000; rd(M_USR, 4'd15, 4'd15, "R6");
        cur_pc = 32'h0000_1003; rd(M_FIQ, 4'd15, 4'd2, "R6");
        cur_pc = 32'h0000_1007; rd(M_SVC, 4'd15, 4'd15, "R6");
        cur_pc = 32'h1234_5679; rd(M_IRQ, 4'd0, 4'd15, "R6");
        cur_pc = 32'hFFFF_FFFE; rd(M_ABT, 4'd15, 4'd15, "R6");
        cur_pc = 32'h0000_2000;

        // R7: register 15 is not storage
        wr(M_SVC, 4'd15, 32'hDEAD_BEEF, "R7");
        rd(M_SVC, 4'd15, 4'd0, "R7");
        for (int i = 0; i < 15; i++) rd(M_SVC, 4'(i), 4'd15, "R7");

        // R8: one saved-status slot per exception mode
        for (int k = 1; k < 6; k++) sw(all_modes[k], 32'h5000_0000 + k, "R8");
        foreach (all_modes[k]) sr(all_modes[k], "R8");

        // R9: no slot in user or system
        sr(M_USR, "R9");
        sw(M_SYS, 32'h0BAD_0BAD, "R9");
        sw(M_USR, 32'h0BAD_0BAD, "R9");
        rd(M_USR, 4'd0, 4'd1, "R9");
        step(M_SYS, 4'd0, 4'd1, 1'b0, 4'd0, 32'h0, 1'b1, 1'b1, 32'h1111_2222, "R9");
        for (int k = 1; k < 6; k++) sr(all_modes[k], "R9");

        // R10: unlisted mode codes follow user mapping
        rd(5'b00000, 4'd13, 4'd14, "R10");
        rd(5'b10100, 4'd9, 4'd12, "R10");
        wr(5'b10100, 4'd13, 32'hAAAA_5555, "R10");
        rd(M_USR, 4'd13, 4'd14, "R10");
        rd(M_SYS, 4'd13, 4'd10, "R10");
        sr(5'b01010, "R10");

        // R11: read during write sees old data
        wr(M_IRQ, 4'd3, 32'h3333_0001, "R11");
        rd(M_IRQ, 4'd3, 4'd3, "R11");
        wr(M_ABT, 4'd13, 32'hABAB_1313, "R11");
        rd(M_ABT, 4'd13, 4'd14, "R11");
        wr(M_FIQ, 4'd9, 32'h9999_F1F1, "R11");
        wr(M_FIQ, 4'd9, 32'h9999_F2F2, "R11");
        rd(M_FIQ, 4'd9, 4'd9, "R11");
        sw(M_UND, 32'hC0DE_0001, "R11");
        sr(M_UND, "R11");

        // R12: independent ports
        rd(M_FIQ, 4'd9, 4'd13, "R12");
        rd(M_UND, 4'd14, 4'd8, "R12");
        rd(M_USR, 4'd5, 4'd12, "R12");

        @(negedge clk);
        wr_en = 1'b0; sps_rd_en = 1'b0; sps_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule